// File: doc/BRIEF.md
# Nine-Bit Address-Match Receive Filter

This block sits behind a serial receiver on a shared half-duplex bus that carries 9-bit words. The top bit of each word marks what kind of word it is. A word with that bit set is an address word. A word with it clear is a data word. The filter checks every address word against the node's own address. While no match is in force, it drops every data word silently. After a match it forwards the payload bytes that follow as a valid/ready byte stream. The first byte carries a start flag, and the last byte carries an end flag or an abort flag.

A packet can close in one of three ways, chosen by a mode input:
- a data byte equal to a configured terminator;
- a fixed number of payload bytes;
- a second copy of the node's own address word.

The node address does not come under this sampling. The mode, the terminator and the length are sampled only at the moment an address matches, so they may change freely while a packet is in flight. A one-cycle pulse on selection lets reply logic begin preparing early.

Back-pressure rules:
- The output beat sits in a single register. It stays unchanged while `out_valid` is high and `out_ready` is low.
- The input accepts a word when `rx_valid && rx_ready`.
- `rx_ready` is high exactly when the output register is empty or is being drained in the same cycle.
- Each accepted word produces at most one output beat.

Top module: `mdrop_rx_filter`

## Requirements
- R1: A word with bit 8 = 1 is an address word (bits 7:0 are the address). A word with bit 8 = 0 is a data word (bits 7:0 are the byte). While deselected, every data word and every address not equal to `node_addr` produces no output beat.
- R2: An accepted address word equal to `node_addr` drives `selected` high and `addr_hit` high for exactly one cycle, both visible after the accepting clock edge.
- R3: With `end_mode` = 0 (code 3 behaves the same), each selected data byte is forwarded at once. The first beat has `out_sop` = 1. The byte equal to `end_byte` is forwarded with `out_eop` = 1, after which the block is deselected.
- R4: With `end_mode` = 2, the block forwards `pkt_len` bytes (1 to 255) and the last of them carries `out_eop` = 1. Further data is then ignored. A length of 1 gives a single beat with `out_sop` and `out_eop` both set.
- R5: With `end_mode` = 1, the newest byte is held back. A repeated own address releases the held byte with `out_eop` = 1 and deselects the block without a new `addr_hit`.
- R6: An address word arriving while selected, after at least one byte has been taken, emits an abort beat with `out_eop` = 1 and `out_abort` = 1. In mode 1 this beat carries the held byte and its start flag. In the other modes it carries data 0 and `out_sop` = 0. The address is then evaluated as in R1/R2.
- R7: A word flagged with `rx_ferr` is discarded. While selected it deselects the block, and it emits an abort beat as in R6 if a byte has been taken. While deselected it has no effect.
- R8: `end_mode`, `end_byte` and `pkt_len` are sampled on the address match. Later changes do not affect the current packet.
- R9: `rx_ready` equals `!out_valid || out_ready`. A stalled output beat holds its value until it is taken.
- R10: After reset, `out_valid`, `selected` and `addr_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received word available |
| rx_ready | output | 1 | Filter can accept a word |
| rx_word | input | 9 | Received word, bit 8 is the address marker |
| rx_ferr | input | 1 | Framing error on this word |
| node_addr | input | 8 | This node's address |
| end_mode | input | 2 | 0 terminator byte, 1 repeated address, 2 fixed length |
| end_byte | input | 8 | Terminator value for mode 0 |
| pkt_len | input | 8 | Payload length for mode 2 |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 8 | Payload byte |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_abort | output | 1 | Packet was cut short |
| addr_hit | output | 1 | One-cycle pulse on own-address match |
| selected | output | 1 | Node currently addressed |

## Verification
A wrong selection state shows up as beats appearing for data that follows a foreign address, or as missing beats after the node's own address. Both become visible at the ports within one handshake of the first data word. A miscounted length or a wrong terminator compare moves `out_eop` onto the wrong byte, and any byte forwarded after that point is counted as an unexpected beat. Trouble with the held byte in repeated-address mode shows as lost, duplicated or reordered bytes, or as a start flag on the wrong beat, when the closing address arrives. A slip in the stall logic shows as a beat that changes while `out_ready` is low, or as `rx_ready` going high during a stall.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  localparam int DW = 8;
  localparam int LW = 8;

  localparam logic [1:0] END_ON_BYTE  = 2'd0;
  localparam logic [1:0] END_ON_ADDR  = 2'd1;
  localparam logic [1:0] END_ON_COUNT = 2'd2;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          sop;
    logic          eop;
    logic          abort;
  } beat_t;
endpackage

// File: rtl/nbf_classify.sv
module nbf_classify
  import nbf_pkg::*;
(
  input  logic [DW:0]   word,
  input  logic [DW-1:0] own,
  output logic          is_addr,
  output logic [DW-1:0] payload,
  output logic          own_hit
);
  always_comb begin
    is_addr = word[DW];
    payload = word[DW-1:0];
    own_hit = word[DW] && (word[DW-1:0] == own);
  end
endmodule

// File: rtl/nbf_seq.sv
module nbf_seq
  import nbf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          is_addr,
  input  logic          own_hit,
  input  logic          ferr,
  input  logic [DW-1:0] payload,
  input  logic [1:0]    cfg_mode,
  input  logic [DW-1:0] cfg_endb,
  input  logic [LW-1:0] cfg_len,
  output logic          emit,
  output beat_t         beat,
  output logic          sel_o,
  output logic          hit_o
);
  logic          sel_q, started_q, first_q, hv_q, hsop_q;
  logic [1:0]    mode_q;
  logic [DW-1:0] endb_q, hb_q;
  logic [LW-1:0] len_q, cnt_q;

  logic          n_sel, n_started, n_first, n_hv, n_hsop, n_hit;
  logic [1:0]    n_mode;
  logic [DW-1:0] n_endb, n_hb;
  logic [LW-1:0] n_len, n_cnt;

  always_comb begin
    n_sel = sel_q; n_started = started_q; n_first = first_q;
    n_hv = hv_q; n_hsop = hsop_q; n_mode = mode_q;
    n_endb = endb_q; n_hb = hb_q; n_len = len_q; n_cnt = cnt_q;
    n_hit = 1'b0;
    emit = 1'b0;
    beat = '0;
    if (acc) begin
      if (ferr) begin
        if (sel_q && started_q) begin
          emit       = 1'b1;
          beat.data  = hv_q ? hb_q : '0;
          beat.sop   = hv_q && hsop_q;
          beat.eop   = 1'b1;
          beat.abort = 1'b1;
        end
        n_sel = 1'b0; n_hv = 1'b0; n_started = 1'b0;
      end else if (is_addr) begin
        if (sel_q && mode_q == END_ON_ADDR && own_hit && hv_q) begin
          emit      = 1'b1;
          beat.data = hb_q;
          beat.sop  = hsop_q;
          beat.eop  = 1'b1;
          n_sel = 1'b0; n_hv = 1'b0; n_started = 1'b0;
        end else begin
          if (sel_q && started_q) begin
            emit       = 1'b1;
            beat.data  = hv_q ? hb_q : '0;
            beat.sop   = hv_q && hsop_q;
            beat.eop   = 1'b1;
            beat.abort = 1'b1;
          end
          n_hv = 1'b0; n_started = 1'b0; n_first = 1'b1; n_cnt = '0;
          n_sel = own_hit;
          if (own_hit) begin
            n_hit  = 1'b1;
            n_mode = cfg_mode;
            n_endb = cfg_endb;
            n_len  = cfg_len;
          end
        end
      end else if (sel_q) begin
        n_started = 1'b1;
        case (mode_q)
          END_ON_ADDR: begin
            if (hv_q) begin
              emit      = 1'b1;
              beat.data = hb_q;
              beat.sop  = hsop_q;
            end
            n_hv   = 1'b1;
            n_hb   = payload;
            n_hsop = !hv_q;
          end
          END_ON_COUNT: begin
            n_cnt     = cnt_q + 1'b1;
            emit      = 1'b1;
            beat.data = payload;
            beat.sop  = first_q;
            beat.eop  = (n_cnt == len_q);
            n_first   = 1'b0;
            if (n_cnt == len_q) begin
              n_sel = 1'b0; n_started = 1'b0;
            end
          end
          default: begin
            emit      = 1'b1;
            beat.data = payload;
            beat.sop  = first_q;
            beat.eop  = (payload == endb_q);
            n_first   = 1'b0;
            if (payload == endb_q) begin
              n_sel = 1'b0; n_started = 1'b0;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0; started_q <= 1'b0; first_q <= 1'b0;
      hv_q <= 1'b0; hsop_q <= 1'b0; mode_q <= END_ON_BYTE;
      endb_q <= '0; hb_q <= '0; len_q <= '0; cnt_q <= '0;
      hit_o <= 1'b0;
    end else begin
      sel_q <= n_sel; started_q <= n_started; first_q <= n_first;
      hv_q <= n_hv; hsop_q <= n_hsop; mode_q <= n_mode;
      endb_q <= n_endb; hb_q <= n_hb; len_q <= n_len; cnt_q <= n_cnt;
      hit_o <= n_hit;
    end
  end

  assign sel_o = sel_q;

  // R7
  ferr_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ferr) |=> !sel_q);

  // R2
  hit_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> sel_q);
endmodule

// File: rtl/nbf_out_reg.sv
module nbf_out_reg
  import nbf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  beat_t din,
  input  logic  ready,
  output logic  valid,
  output beat_t dout,
  output logic  free
);
  assign free = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import nbf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW:0]   rx_word,
  input  logic          rx_ferr,
  input  logic [DW-1:0] node_addr,
  input  logic [1:0]    end_mode,
  input  logic [DW-1:0] end_byte,
  input  logic [LW-1:0] pkt_len,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_abort,
  output logic          addr_hit,
  output logic          selected
);
  logic          is_addr, own_hit, emit, acc, free;
  logic [DW-1:0] payload;
  beat_t         nbeat, obeat;

  assign rx_ready = free;
  assign acc      = rx_valid && free;

  nbf_classify u_cls (
    .word(rx_word), .own(node_addr),
    .is_addr(is_addr), .payload(payload), .own_hit(own_hit)
  );

  nbf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .is_addr(is_addr),
    .own_hit(own_hit), .ferr(rx_ferr), .payload(payload),
    .cfg_mode(end_mode), .cfg_endb(end_byte), .cfg_len(pkt_len),
    .emit(emit), .beat(nbeat), .sel_o(selected), .hit_o(addr_hit)
  );

  nbf_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .din(nbeat),
    .ready(out_ready), .valid(out_valid), .dout(obeat), .free(free)
  );

  assign out_data  = obeat.data;
  assign out_sop   = obeat.sop;
  assign out_eop   = obeat.eop;
  assign out_abort = obeat.abort;

  // R1
  beat_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(selected));
endmodule

// File: tb/sim_mdrop_rx_filter.sv
`timescale 1ns/1ps
module sim_mdrop_rx_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_ferr = 1'b0, out_ready = 1'b1;
  logic [8:0] rx_word = '0;
  logic [7:0] node_addr = 8'h25, end_byte = 8'h7E, pkt_len = 8'd3;
  logic [1:0] end_mode = 2'd0;
  logic rx_ready, out_valid, out_sop, out_eop, out_abort, addr_hit, selected;
  logic [7:0] out_data;

  int checks = 0, fails = 0, beats = 0, hits = 0, exp_hits = 0;
  logic [10:0] expq[$];
  bit rand_ready = 1'b0;

  localparam logic [8:0] OWN = {1'b1, 8'h25};
  localparam logic [8:0] FOR = {1'b1, 8'h3A};

  always #2 clk = ~clk;

  mdrop_rx_filter u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_word(rx_word), .rx_ferr(rx_ferr), .node_addr(node_addr),
    .end_mode(end_mode), .end_byte(end_byte), .pkt_len(pkt_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_abort(out_abort),
    .addr_hit(addr_hit), .selected(selected)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expb(input logic [7:0] d, input bit s, input bit e, input bit a);
    expq.push_back({d, s, e, a});
  endtask

  task automatic send(input logic [8:0] w, input bit fe);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_word = w; rx_ferr = fe;
    do @(negedge clk); while (!rx_ready);
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((expq.size() != 0 || out_valid) && n < 1000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    check(expq.size() == 0, req, "missing beats", expq.size(), 0);
    check(hits == exp_hits, req, "addr_hit count", hits, exp_hits);
  endtask

  // ready pattern
  initial forever begin
    @(posedge clk); #1;
    out_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (addr_hit) hits++;
    if (out_valid && !out_ready)
      check(rx_ready == 1'b0, "R9", "rx_ready during stall", rx_ready, 0);
    if (out_valid && out_ready) begin
      beats++;
      if (expq.size() == 0) begin
        check(1'b0, "R1", "unexpected beat", {out_data, out_sop, out_eop, out_abort}, 0);
      end else begin
        logic [10:0] e;
        e = expq.pop_front();
        check({out_data, out_sop, out_eop, out_abort} == e, "R3-R7 data",
              "beat {data,sop,eop,abort}",
              {out_data, out_sop, out_eop, out_abort}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid == 0, "R10", "out_valid", out_valid, 0);
    check(selected == 0, "R10", "selected", selected, 0);
    check(addr_hit == 0, "R10", "addr_hit", addr_hit, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 idle data and foreign address ignored
    b0 = beats;
    send(9'h011, 0); send(9'h07E, 0); send(FOR, 0); send(9'h022, 0); send(9'h07E, 0);
    drain("R1");
    check(beats == b0, "R1", "beats while deselected", beats - b0, 0);
    check(selected == 0, "R1", "selected after foreign", selected, 0);

    // R2/R3 terminator mode
    end_mode = 2'd0;
    send(OWN, 0); exp_hits++;
    @(negedge clk);
    check(selected == 1, "R2", "selected after match", selected, 1);
    send(9'h011, 0); expb(8'h11, 1, 0, 0);
    send(9'h022, 0); expb(8'h22, 0, 0, 0);
    send(9'h07E, 0); expb(8'h7E, 0, 1, 0);
    send(9'h033, 0);
    drain("R3");
    check(selected == 0, "R3", "deselected after end byte", selected, 0);

    // R4 fixed length, with back-pressure
    rand_ready = 1'b1;
    end_mode = 2'd2; pkt_len = 8'd3;
    send(OWN, 0); exp_hits++;
    send(9'h0A1, 0); expb(8'hA1, 1, 0, 0);
    send(9'h0B2, 0); expb(8'hB2, 0, 0, 0);
    send(9'h0C3, 0); expb(8'hC3, 0, 1, 0);
    send(9'h0D4, 0);
    drain("R4");
    pkt_len = 8'd1;
    send(OWN, 0); exp_hits++;
    send(9'h055, 0); expb(8'h55, 1, 1, 0);
    send(9'h066, 0);
    drain("R4");

    // R5 repeated address
    end_mode = 2'd1;
    send(OWN, 0); exp_hits++;
    send(9'h001, 0); expb(8'h01, 1, 0, 0);
    send(9'h002, 0); expb(8'h02, 0, 0, 0);
    send(9'h003, 0); expb(8'h03, 0, 1, 0);
    send(OWN, 0);
    send(9'h004, 0);
    drain("R5");
    check(selected == 0, "R5", "deselected after repeat", selected, 0);

    // R6 abort by foreign address, repeat mode (held byte carried)
    send(OWN, 0); exp_hits++;
    send(9'h009, 0); expb(8'h09, 1, 1, 1);
    send(FOR, 0);
    send(9'h00A, 0);
    drain("R6");

    // R6 abort by own address in terminator mode, reselect
    end_mode = 2'd0;
    send(OWN, 0); exp_hits++;
    send(9'h005, 0); expb(8'h05, 1, 0, 0);
    send(9'h006, 0); expb(8'h06, 0, 0, 0);
    send(OWN, 0); expb(8'h00, 0, 1, 1); exp_hits++;
    send(9'h012, 0); expb(8'h12, 1, 0, 0);
    send(9'h07E, 0); expb(8'h7E, 0, 1, 0);
    drain("R6");

    // R7 framing error while selected, then ignored while idle
    send(OWN, 0); exp_hits++;
    send(9'h001, 0); expb(8'h01, 1, 0, 0);
    send(9'h0EE, 1); expb(8'h00, 0, 1, 1);
    send(9'h002, 0);
    send(OWN, 1);
    drain("R7");
    check(selected == 0, "R7", "selected after ferr", selected, 0);

    // R8 config sampled at match
    end_mode = 2'd2; pkt_len = 8'd2;
    send(OWN, 0); exp_hits++;
    pkt_len = 8'd5; end_mode = 2'd0;
    send(9'h07E, 0); expb(8'h7E, 1, 0, 0);
    send(9'h0B0, 0); expb(8'hB0, 0, 1, 0);
    send(9'h0C0, 0);
    drain("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule